// File: doc/BRIEF.md
# Flash Byte Program-and-Verify Sequencer

This block sits on the host side of a parallel flash device that is controlled through command writes. A single start pulse hands it a target address and a data byte. The block then runs a full program-and-verify loop on the device's strobes and buses. Each attempt has five steps:

- write the program-setup command;
- write the data to the target address;
- write the program-verify command;
- wait for the device's internal margin level to settle;
- read the location back and compare it with the intended byte.

A mismatch starts a fresh attempt. The number of attempts is capped. When the loop ends, on a pass or when the cap is reached, the block writes the read command so the device is back in array-read mode. It then reports completion with a pass flag and the attempt count.

Each strobe phase has a length in clock cycles that is set by a parameter: address and data setup, write-enable low time, hold after the rising edge, and read-enable time. The settle wait is also a cycle count; at 125 MHz, about 6 µs is 750 cycles. The asynchronous reset is synchronised inside the block before it reaches the logic.

Top module: `flash_pgm_seq`

## Requirements
- R1: After reset, flash_ce_n, flash_we_n and flash_oe_n are 1, flash_dq_oe is 0, and busy and done are 0.
- R2: Every attempt consists of three writes to the target address, in this order: 8'h40 (program setup), then the start data, then 8'hC0 (program verify).
- R3: In a write cycle, chip enable is low and address and data are driven for T_SETUP cycles before write enable falls. Write enable then stays low for exactly T_WE cycles, with address and data stable. Chip enable and the buses are held for T_HOLD cycles after write enable rises.
- R4: Read enable does not fall until at least VERIFY_WAIT clock cycles after write enable rises on the 8'hC0 command.
- R5: A read cycle drives read enable and chip enable low with flash_dq_oe at 0. Read enable and write enable are never low together.
- R6: When the data read back equals the start data, the block writes 8'h00 and then pulses done with pass=1. attempts shows the number of attempts used, where the first attempt counts as 1.
- R7: On a mismatch below the cap, the whole three-write, wait and read attempt repeats, and attempts increases by one.
- R8: After MAX_TRIES mismatching attempts, the block writes 8'h00 and pulses done with pass=0 and attempts=MAX_TRIES. The total is 3*MAX_TRIES+1 writes.
- R9: A start pulse while busy=1 is ignored: it writes nothing, leaves its address untouched, and produces no extra done.
- R10: done is high for exactly one cycle and busy is already 0 in that cycle. pass and attempts hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to program a byte |
| start_addr | input | AW | Target address |
| start_data | input | DW | Byte to program |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Last sequence verified |
| attempts | output | clog2(MAX_TRIES+1) | Attempts used by the last sequence |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_we_n | output | 1 | Write enable, active low |
| flash_oe_n | output | 1 | Read enable, active low |
| flash_addr | output | AW | Address bus |
| flash_dq_o | output | DW | Data bus, outbound |
| flash_dq_oe | output | 1 | Data bus drive enable |
| flash_dq_i | input | DW | Data bus, inbound |

## Verification
The assertions check on every cycle the properties that hold independently of any scenario:

- write enable is only low while chip enable is low;
- read enable and write enable never overlap, and the bus is released during reads;
- address and data are stable while write enable is low;
- the attempt counter stays within its cap, and a fail report carries exactly the cap;
- done is a single-cycle pulse, and a start arriving while busy leaves the latched target unchanged.

Only the bench scenarios, which use a behavioural device model that can refuse a set number of programs, can show the rest:

- the command order and the total number of writes;
- the write-enable low width and the settle gap before read-back;
- the attempt counts for first-time, late and never-succeeding programs;
- the untouched memory location after an ignored start.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  localparam logic [7:0] CMD_READ   = 8'h00;
  localparam logic [7:0] CMD_PSETUP = 8'h40;
  localparam logic [7:0] CMD_PVERIFY = 8'hC0;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_LOW, PH_HOLD, PH_READ
  } bus_phase_e;

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_PROG, S_VCMD, S_WAIT, S_READ, S_CMP, S_RCMD
  } seq_state_e;

endpackage

// File: rtl/flash_bus_phy.sv
module flash_bus_phy
  import flash_seq_pkg::*;
#(
  parameter int AW      = 17,
  parameter int DW      = 8,
  parameter int T_SETUP = 2,
  parameter int T_WE    = 4,
  parameter int T_HOLD  = 1,
  parameter int T_RD    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          go_wr,
  input  logic [AW-1:0] go_addr,
  input  logic [DW-1:0] go_data,
  output logic          op_done,
  output logic [DW-1:0] rd_data,
  output logic          ce_n,
  output logic          we_n,
  output logic          oe_n,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe,
  input  logic [DW-1:0] dq_i
);

  localparam int TMAX_A = (T_SETUP > T_WE) ? T_SETUP : T_WE;
  localparam int TMAX_B = (T_HOLD > T_RD) ? T_HOLD : T_RD;
  localparam int TMAX   = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
  localparam int CW     = $clog2(TMAX + 1);

  bus_phase_e    ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q, rd_q;
  logic          ld_en, cap_en;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    if (ph_q == PH_IDLE) begin
      if (go) begin
        ph_d  = go_wr ? PH_SETUP : PH_READ;
        cnt_d = go_wr ? CW'(T_SETUP - 1) : CW'(T_RD - 1);
      end
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end else begin
      unique case (ph_q)
        PH_SETUP: begin ph_d = PH_LOW;  cnt_d = CW'(T_WE - 1);   end
        PH_LOW:   begin ph_d = PH_HOLD; cnt_d = CW'(T_HOLD - 1); end
        default:  begin ph_d = PH_IDLE; cnt_d = '0;              end
      endcase
    end
  end

  assign ld_en   = (ph_q == PH_IDLE) && go;
  assign cap_en  = (ph_q == PH_READ) && (cnt_q == '0);
  assign op_done = ((ph_q == PH_HOLD) || (ph_q == PH_READ)) && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (ld_en) begin
      addr_q <= go_addr;
      data_q <= go_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_q <= '0;
    else if (cap_en) rd_q <= dq_i;
  end

  assign ce_n    = (ph_q == PH_IDLE);
  assign we_n    = (ph_q != PH_LOW);
  assign oe_n    = (ph_q != PH_READ);
  assign dq_oe   = (ph_q == PH_SETUP) || (ph_q == PH_LOW) || (ph_q == PH_HOLD);
  assign addr    = addr_q;
  assign dq_o    = data_q;
  assign rd_data = rd_q;

  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !ce_n); // R3
  AST_BUS_STABLE_WE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && $past(!we_n)) |-> ($stable(addr) && $stable(dq_o))); // R3
  AST_NO_STROBE_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !oe_n)); // R5
  AST_BUS_FREE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!dq_oe && !ce_n)); // R5

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int AW          = 17,
  parameter int DW          = 8,
  parameter int MAX_TRIES   = 25,
  parameter int VERIFY_WAIT = 750
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic [AW-1:0]                  start_addr,
  input  logic [DW-1:0]                  start_data,
  output logic                           busy,
  output logic                           done,
  output logic                           pass,
  output logic [$clog2(MAX_TRIES+1)-1:0] attempts,
  output logic                           op_go,
  output logic                           op_wr,
  output logic [AW-1:0]                  op_addr,
  output logic [DW-1:0]                  op_data,
  input  logic                           phy_done,
  input  logic [DW-1:0]                  rd_data
);

  localparam int TW = $clog2(MAX_TRIES + 1);
  localparam int WW = $clog2(VERIFY_WAIT + 1);

  seq_state_e    st_q, st_d;
  logic [TW-1:0] tries_q;
  logic [WW-1:0] wcnt_q, wcnt_d;
  logic [AW-1:0] tgt_addr_q;
  logic [DW-1:0] tgt_data_q;
  logic          launched_q, launched_d;
  logic          pass_q, done_q, done_d;
  logic          tgt_ld, tries_inc, pass_set, is_op;

  always_comb begin
    st_d      = st_q;
    wcnt_d    = wcnt_q;
    tgt_ld    = 1'b0;
    tries_inc = 1'b0;
    pass_set  = 1'b0;
    done_d    = 1'b0;
    unique case (st_q)
      S_IDLE:  if (start) begin st_d = S_SETUP; tgt_ld = 1'b1; end
      S_SETUP: if (phy_done) st_d = S_PROG;
      S_PROG:  if (phy_done) st_d = S_VCMD;
      S_VCMD:  if (phy_done) begin st_d = S_WAIT; wcnt_d = '0; end
      S_WAIT: begin
        if (wcnt_q == WW'(VERIFY_WAIT - 1)) st_d = S_READ;
        else wcnt_d = wcnt_q + 1'b1;
      end
      S_READ:  if (phy_done) st_d = S_CMP;
      S_CMP: begin
        if (rd_data == tgt_data_q) begin
          pass_set = 1'b1;
          st_d     = S_RCMD;
        end else if (tries_q == TW'(MAX_TRIES)) begin
          st_d = S_RCMD;
        end else begin
          tries_inc = 1'b1;
          st_d      = S_SETUP;
        end
      end
      S_RCMD:  if (phy_done) begin st_d = S_IDLE; done_d = 1'b1; end
      default: st_d = S_IDLE;
    endcase
  end

  assign is_op = (st_q == S_SETUP) || (st_q == S_PROG) || (st_q == S_VCMD) ||
                 (st_q == S_READ)  || (st_q == S_RCMD);
  assign op_go = is_op && !launched_q;
  assign launched_d = phy_done ? 1'b0 : (op_go ? 1'b1 : launched_q);

  always_comb begin
    op_wr = (st_q != S_READ);
    unique case (st_q)
      S_SETUP: op_data = DW'(CMD_PSETUP);
      S_PROG:  op_data = tgt_data_q;
      S_VCMD:  op_data = DW'(CMD_PVERIFY);
      default: op_data = DW'(CMD_READ);
    endcase
  end
  assign op_addr = tgt_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      wcnt_q     <= '0;
      launched_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      st_q       <= st_d;
      wcnt_q     <= wcnt_d;
      launched_q <= launched_d;
      done_q     <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_addr_q <= '0;
      tgt_data_q <= '0;
    end else if (tgt_ld) begin
      tgt_addr_q <= start_addr;
      tgt_data_q <= start_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tries_q <= '0;
      pass_q  <= 1'b0;
    end else begin
      if (tgt_ld)         tries_q <= TW'(1);
      else if (tries_inc) tries_q <= tries_q + 1'b1;
      if (tgt_ld)         pass_q  <= 1'b0;
      else if (pass_set)  pass_q  <= 1'b1;
    end
  end

  assign busy     = (st_q != S_IDLE);
  assign done     = done_q;
  assign pass     = pass_q;
  assign attempts = tries_q;

  AST_TRIES_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    tries_q <= TW'(MAX_TRIES)); // R8
  AST_FAIL_AT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !pass) |-> (attempts == TW'(MAX_TRIES))); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(tgt_addr_q)); // R9
  AST_READ_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == S_READ) |-> ($past(st_q) == S_WAIT)); // R4

endmodule

// File: rtl/flash_pgm_seq.sv
module flash_pgm_seq
  import flash_seq_pkg::*;
#(
  parameter int AW          = 17,
  parameter int DW          = 8,
  parameter int T_SETUP     = 2,
  parameter int T_WE        = 4,
  parameter int T_HOLD      = 1,
  parameter int T_RD        = 3,
  parameter int VERIFY_WAIT = 750,
  parameter int MAX_TRIES   = 25
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic [AW-1:0]                  start_addr,
  input  logic [DW-1:0]                  start_data,
  output logic                           busy,
  output logic                           done,
  output logic                           pass,
  output logic [$clog2(MAX_TRIES+1)-1:0] attempts,
  output logic                           flash_ce_n,
  output logic                           flash_we_n,
  output logic                           flash_oe_n,
  output logic [AW-1:0]                  flash_addr,
  output logic [DW-1:0]                  flash_dq_o,
  output logic                           flash_dq_oe,
  input  logic [DW-1:0]                  flash_dq_i
);

  logic          rst_meta, rst_sync;
  logic          op_go, op_wr, phy_done;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  flash_seq_ctrl #(
    .AW(AW), .DW(DW), .MAX_TRIES(MAX_TRIES), .VERIFY_WAIT(VERIFY_WAIT)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_sync),
    .start(start), .start_addr(start_addr), .start_data(start_data),
    .busy(busy), .done(done), .pass(pass), .attempts(attempts),
    .op_go(op_go), .op_wr(op_wr), .op_addr(op_addr), .op_data(op_data),
    .phy_done(phy_done), .rd_data(rd_data)
  );

  flash_bus_phy #(
    .AW(AW), .DW(DW), .T_SETUP(T_SETUP), .T_WE(T_WE), .T_HOLD(T_HOLD), .T_RD(T_RD)
  ) u_phy (
    .clk(clk), .rst_n(rst_sync),
    .go(op_go), .go_wr(op_wr), .go_addr(op_addr), .go_data(op_data),
    .op_done(phy_done), .rd_data(rd_data),
    .ce_n(flash_ce_n), .we_n(flash_we_n), .oe_n(flash_oe_n),
    .addr(flash_addr), .dq_o(flash_dq_o), .dq_oe(flash_dq_oe), .dq_i(flash_dq_i)
  );

endmodule

// File: tb/flash_pgm_seq_tb.sv
module flash_pgm_seq_tb;

  localparam int AW = 17, DW = 8;
  localparam int T_SETUP = 2, T_WE = 3, T_HOLD = 1, T_RD = 2;
  localparam int VWAIT = 20, MAXT = 25;
  localparam int TW = $clog2(MAXT + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [DW-1:0] start_data = '0;
  logic busy, done, pass;
  logic [TW-1:0] attempts;
  logic ce_n, we_n, oe_n, dq_oe;
  logic [AW-1:0] faddr;
  logic [DW-1:0] dq_o, dq_i;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  flash_pgm_seq #(
    .AW(AW), .DW(DW), .T_SETUP(T_SETUP), .T_WE(T_WE), .T_HOLD(T_HOLD),
    .T_RD(T_RD), .VERIFY_WAIT(VWAIT), .MAX_TRIES(MAXT)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .start_data(start_data), .busy(busy), .done(done), .pass(pass),
    .attempts(attempts), .flash_ce_n(ce_n), .flash_we_n(we_n),
    .flash_oe_n(oe_n), .flash_addr(faddr), .flash_dq_o(dq_o),
    .flash_dq_oe(dq_oe), .flash_dq_i(dq_i)
  );

  // behavioural flash device
  logic [7:0] mem [256];
  int         mode = 0;     // 0 array read, 1 program pending, 2 verify
  logic [7:0] lat_a = 8'h00;
  logic [7:0] v_a = 8'h00;
  int         fail_budget = 0;
  int         wr_count = 0;
  logic [7:0] wr_log [128];

  always @(negedge we_n) lat_a = faddr[7:0];

  always @(posedge we_n) begin
    if (ce_n === 1'b0) begin
      if (wr_count < 128) wr_log[wr_count] = dq_o;
      wr_count++;
      if (mode == 1) begin
        if (fail_budget > 0) fail_budget--;
        else mem[lat_a] = mem[lat_a] & dq_o;
        v_a  = lat_a;
        mode = 0;
      end else if (dq_o == 8'h40) mode = 1;
      else if (dq_o == 8'hC0) mode = 2;
      else mode = 0;
    end
  end

  assign dq_i = oe_n ? 8'h00 : ((mode == 2) ? mem[v_a] : mem[faddr[7:0]]);

  // strobe monitor sampled away from the active edge
  int cyc = 0, we_run = 0, min_we_low = 1000, max_we_low = 0;
  int c0_rise = 0, min_gap = 100000;
  logic prev_we = 1'b1, prev_oe = 1'b1;
  always @(negedge clk) begin
    cyc++;
    if (!we_n) we_run++;
    if (we_n && !prev_we) begin
      if (we_run < min_we_low) min_we_low = we_run;
      if (we_run > max_we_low) max_we_low = we_run;
      we_run = 0;
      if (dq_o == 8'hC0) c0_rise = cyc;
    end
    if (!oe_n && prev_oe && (cyc - c0_rise < min_gap)) min_gap = cyc - c0_rise;
    prev_we = we_n;
    prev_oe = oe_n;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic kick(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    start_addr = AW'(a);
    start_data = d;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    check(done, req, 0, 1);
    check(!busy, "R10 busy low with done", busy, 0);
  endtask

  task automatic test_reset();
    check(ce_n && we_n && oe_n, "R1 strobes idle", {ce_n, we_n, oe_n}, 7);
    check(!dq_oe, "R1 bus released", dq_oe, 0);
    check(!busy && !done, "R1 busy/done low", {busy, done}, 0);
  endtask

  task automatic test_first_pass();
    wr_count = 0; fail_budget = 0;
    kick(8'h12, 8'h5A);
    wait_done("R6 done");
    check(pass, "R6 pass", pass, 1);
    check(attempts == 1, "R6 attempts", attempts, 1);
    check(wr_log[0] == 8'h40, "R2 setup cmd", wr_log[0], 8'h40);
    check(wr_log[1] == 8'h5A, "R2 data write", wr_log[1], 8'h5A);
    check(wr_log[2] == 8'hC0, "R2 verify cmd", wr_log[2], 8'hC0);
    check(wr_log[3] == 8'h00, "R6 read cmd", wr_log[3], 8'h00);
    check(wr_count == 4, "R6 write count", wr_count, 4);
    check(mem[8'h12] == 8'h5A, "R2 target programmed", mem[8'h12], 8'h5A);
    @(negedge clk);
    check(!done, "R10 done one cycle", done, 0);
    check(pass && attempts == 1, "R10 results held", attempts, 1);
  endtask

  task automatic test_retry();
    wr_count = 0; fail_budget = 3;
    kick(8'h21, 8'hA5);
    wait_done("R7 done");
    check(pass, "R7 pass after retries", pass, 1);
    check(attempts == 4, "R7 attempts", attempts, 4);
    check(wr_count == 13, "R7 write count", wr_count, 13);
    check(wr_log[3] == 8'h40 && wr_log[4] == 8'hA5, "R7 loop restarts", wr_log[3], 8'h40);
  endtask

  task automatic test_exhaust();
    wr_count = 0; fail_budget = 1000;
    kick(8'h30, 8'h33);
    wait_done("R8 done");
    check(!pass, "R8 fail reported", pass, 0);
    check(attempts == MAXT, "R8 attempts at cap", attempts, MAXT);
    check(wr_count == 3 * MAXT + 1, "R8 write count", wr_count, 3 * MAXT + 1);
    check(wr_log[3 * MAXT] == 8'h00, "R8 read cmd last", wr_log[3 * MAXT], 0);
    fail_budget = 0;
  endtask

  task automatic test_busy_start();
    int dn = 0;
    wr_count = 0;
    kick(8'h44, 8'h0F);
    repeat (5) @(negedge clk);
    start_addr = AW'(8'h50); start_data = 8'h00; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done("R9 done");
    check(wr_count == 4, "R9 no extra writes", wr_count, 4);
    check(mem[8'h50] == 8'hFF, "R9 ignored address untouched", mem[8'h50], 8'hFF);
    check(mem[8'h44] == 8'h0F, "R9 original programmed", mem[8'h44], 8'h0F);
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (done) dn++; end
    check(dn == 0 && !busy, "R9 no second sequence", dn, 0);
  endtask

  task automatic test_timing();
    check(min_we_low == T_WE && max_we_low == T_WE, "R3 we low width", min_we_low, T_WE);
    check(min_gap >= VWAIT, "R4 settle gap", min_gap, VWAIT);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    test_reset();
    test_first_pass();
    test_retry();
    test_exhaust();
    test_busy_start();
    test_timing();
    finish_run();
  end

endmodule